// File: doc/BRIEF.md
# Compare-Match Timer Channel

A single timer channel built around a 32-bit up-counter that is compared against a programmable limit. A local prescaler derives the count rate from the input clock with one of four ratios. Counting runs only while the external start input is high; that input is one channel's bit from a start/stop register held outside this block. When the counter equals the limit, the next count returns it to zero and a sticky match flag is set. The match can raise a level interrupt or a one-cycle DMA request.

Host access is a plain word-indexed register port with three words: control/status, counter and compare. Compare writes take effect at once. Counter writes are staged and land a fixed number of input clocks later, and a busy bit in the status word shows when a staged value is still waiting. The sticky flags are cleared by writing zero to their bit positions. A continuous mode restarts the count after every match. In single mode the counter stays at zero after a match until software clears the match flag.

Top module: `match_timer`

## Requirements
- R1: After reset the control/status word reads 0, the counter reads 0, the compare word reads all ones, and `irq` and `dma_req` are low.
- R2: `reg_sel` 0 selects control/status, 1 the counter and 2 the compare word. Selector 3 reads zero and writes to it change nothing. Control/status layout: bit 15 match flag, bit 14 wrap flag, bit 13 load-busy, bit 8 continuous mode, bit 7 interrupt enable, bits 5:4 request route, bits 2:0 clock select. All other bits read zero.
- R3: Clock select 4, 5, 6 and 7 give one count every 8, 32, 128 and 1 input clocks. Any other value stops counting. The prescaler phase restarts whenever `run_en` is low, so E running clocks give floor(E/ratio) counts.
- R4: While `run_en` is low and no counter load is pending, the counter holds its value.
- R5: In continuous mode (bit 8 = 1), a count taken while the counter equals the compare value sets the counter to 0 and sets the match flag. The period is therefore compare+1 counts.
- R6: In single mode (bit 8 = 0), once the match flag is set the counter stays at 0 until the flag is cleared, and then resumes counting.
- R7: A count taken at all ones with no compare match wraps the counter to 0 and sets the wrap flag, not the match flag. With the compare word at all ones, the counter runs the full range and sets the match flag at the wrap instead.
- R8: A control/status write with 0 in bit 15 or bit 14 clears that flag, and writing 1 leaves it unchanged. A flag event in the same cycle wins over the clear.
- R9: A counter write sets load-busy. The value appears in the counter on the third clock edge after the write edge (WR_DELAY = 3), and load-busy drops at that edge. On that edge the load has priority over a count.
- R10: `irq` is high exactly while the match flag, the interrupt enable and route = 2'b10 are all set.
- R11: With route = 2'b01, each match gives a one-clock `dma_req` pulse in the cycle after the matching edge, and `irq` stays low.
- R12: A compare write takes effect on the next clock edge and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Start bit for this channel from the external start/stop register |
| reg_sel | input | 2 | Word selector: 0 control/status, 1 counter, 2 compare |
| reg_we | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| irq | output | 1 | Level interrupt request |
| dma_req | output | 1 | One-cycle DMA request pulse |

## Verification
The hardest case to reach is the wrap without a match: the counter must reach all ones while the compare value is smaller. The stimulus gets there by a staged counter write of all-ones-minus-one with the count stopped, then two counts at ratio 1. The same setup with the compare word at all ones covers the full-range match. Single-mode hold and the priority of a staged load over a running count are checked on exact clock edges. Random ratios, limits and run lengths are checked against floor-and-modulo predictions.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

   typedef enum logic [1:0] {
      ROUTE_NONE = 2'b00,
      ROUTE_DMA  = 2'b01,
      ROUTE_IRQ  = 2'b10,
      ROUTE_RSVD = 2'b11
   } route_e;

   localparam logic [1:0] WSEL_CTRL  = 2'd0;
   localparam logic [1:0] WSEL_COUNT = 2'd1;
   localparam logic [1:0] WSEL_LIMIT = 2'd2;

   localparam int BIT_HIT   = 15;
   localparam int BIT_WRAP  = 14;
   localparam int BIT_BUSY  = 13;
   localparam int BIT_CONT  = 8;
   localparam int BIT_IE    = 7;

   typedef struct packed {
      logic       cont;
      logic       hit_ie;
      route_e     route;
      logic [2:0] clk_sel;
   } ctrl_t;

endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
   parameter int LOG_A = 3,
   parameter int LOG_B = 5,
   parameter int LOG_C = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_en,
   input  logic [2:0] clk_sel,
   output logic       tick
);
   localparam int PW = (LOG_C < 1) ? 1 : LOG_C;
   localparam logic [PW-1:0] LIM_A = PW'((1 << LOG_A) - 1);
   localparam logic [PW-1:0] LIM_B = PW'((1 << LOG_B) - 1);
   localparam logic [PW-1:0] LIM_C = PW'((1 << LOG_C) - 1);

   if (!(LOG_A >= 1 && LOG_A < LOG_B && LOG_B < LOG_C && LOG_C <= 16)) begin : g_bad_ratio
      $error("mt_prescaler: ratio exponents must rise strictly");
   end

   logic [PW-1:0] pre_q;
   logic [PW-1:0] limit;
   logic          active;

   always_comb begin
      active = 1'b1;
      unique case (clk_sel)
         3'd4:    limit = LIM_A;
         3'd5:    limit = LIM_B;
         3'd6:    limit = LIM_C;
         3'd7:    limit = '0;
         default: begin
            limit  = '0;
            active = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run_en || !active || pre_q >= limit) pre_q <= '0;
      else                                                 pre_q <= pre_q + 1'b1;
   end

   assign tick = run_en && active && (pre_q == limit);

   a_r4_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> run_en);

endmodule

// File: rtl/mt_loader.sv
module mt_loader #(
   parameter int W     = 32,
   parameter int DELAY = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic         busy,
   output logic         load,
   output logic [W-1:0] load_val
);
   logic [W-1:0] val_q;
   logic         busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  val_q <= '0;
      else if (wr) val_q <= wdata;
   end

   if (DELAY == 1) begin : g_direct
      always_ff @(posedge clk) begin
         if (!rst_n)  busy_q <= 1'b0;
         else if (wr) busy_q <= 1'b1;
         else         busy_q <= 1'b0;
      end
      assign load = busy_q;
   end else begin : g_counted
      localparam int DW = $clog2(DELAY + 1);
      logic [DW-1:0] dly_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            dly_q  <= '0;
         end else if (wr) begin
            busy_q <= 1'b1;
            dly_q  <= DW'(DELAY);
         end else if (busy_q) begin
            if (dly_q == DW'(1)) begin
               busy_q <= 1'b0;
               dly_q  <= '0;
            end else begin
               dly_q <= dly_q - 1'b1;
            end
         end
      end
      assign load = busy_q && (dly_q == DW'(1));
   end

   assign busy     = busy_q;
   assign load_val = val_q;

   a_r9_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> busy);

endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         hit_ev,
   output logic         wrap_ev
);
   localparam logic [W-1:0] ALL1 = {W{1'b1}};

   logic [W-1:0] cnt_q;

   assign hit_ev  = tick && !load && (cnt_q == limit);
   assign wrap_ev = tick && !load && (cnt_q != limit) && (cnt_q == ALL1);

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (load)              cnt_q <= load_val;
      else if (hit_ev || wrap_ev) cnt_q <= '0;
      else if (tick)              cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;

   a_r5_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ev |=> (count == '0));
   a_r7_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_ev |=> (count == '0));
   a_r9_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count == $past(load_val)));

endmodule

// File: rtl/match_timer.sv
module match_timer
   import mtimer_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int WR_DELAY = 3,
   parameter int LOG_A    = 3,
   parameter int LOG_B    = 5,
   parameter int LOG_C    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [1:0]       reg_sel,
   input  logic             reg_we,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   output logic             irq,
   output logic             dma_req
);
   if (CNT_W < 16 || CNT_W > 64) begin : g_bad_width
      $error("match_timer: CNT_W must lie in 16..64");
   end
   if (WR_DELAY < 1 || WR_DELAY > 15) begin : g_bad_delay
      $error("match_timer: WR_DELAY must lie in 1..15");
   end

   localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

   logic wr_ctrl, wr_count, wr_limit;
   assign wr_ctrl  = reg_we && (reg_sel == WSEL_CTRL);
   assign wr_count = reg_we && (reg_sel == WSEL_COUNT);
   assign wr_limit = reg_we && (reg_sel == WSEL_LIMIT);

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] limit_q;
   logic             hit_q, wrap_q, dma_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.cont    <= reg_wdata[BIT_CONT];
         ctrl_q.hit_ie  <= reg_wdata[BIT_IE];
         ctrl_q.route   <= route_e'(reg_wdata[5:4]);
         ctrl_q.clk_sel <= reg_wdata[2:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        limit_q <= ALL1;
      else if (wr_limit) limit_q <= reg_wdata;
   end

   logic pre_tick, run_tick, hold;

   mt_prescaler #(.LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) pre_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_en  (run_en),
      .clk_sel (ctrl_q.clk_sel),
      .tick    (pre_tick)
   );

   assign hold     = !ctrl_q.cont && hit_q;
   assign run_tick = pre_tick && !hold;

   logic             busy, load;
   logic [CNT_W-1:0] load_val;

   mt_loader #(.W(CNT_W), .DELAY(WR_DELAY)) ldr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_count),
      .wdata    (reg_wdata),
      .busy     (busy),
      .load     (load),
      .load_val (load_val)
   );

   logic [CNT_W-1:0] count;
   logic             hit_ev, wrap_ev;

   mt_counter #(.W(CNT_W)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (run_tick),
      .load     (load),
      .load_val (load_val),
      .limit    (limit_q),
      .count    (count),
      .hit_ev   (hit_ev),
      .wrap_ev  (wrap_ev)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q  <= 1'b0;
         wrap_q <= 1'b0;
         dma_q  <= 1'b0;
      end else begin
         if (hit_ev)       hit_q <= 1'b1;
         else if (wr_ctrl) hit_q <= hit_q && reg_wdata[BIT_HIT];
         if (wrap_ev)      wrap_q <= 1'b1;
         else if (wr_ctrl) wrap_q <= wrap_q && reg_wdata[BIT_WRAP];
         dma_q <= hit_ev && (ctrl_q.route == ROUTE_DMA);
      end
   end

   assign irq     = hit_q && ctrl_q.hit_ie && (ctrl_q.route == ROUTE_IRQ);
   assign dma_req = dma_q;

   logic [15:0] status_word;
   assign status_word = {hit_q, wrap_q, busy, 4'b0000, ctrl_q.cont, ctrl_q.hit_ie,
                         1'b0, ctrl_q.route, 1'b0, ctrl_q.clk_sel};

   always_comb begin
      reg_rdata = '0;
      unique case (reg_sel)
         WSEL_CTRL:  reg_rdata[15:0] = status_word;
         WSEL_COUNT: reg_rdata = count;
         WSEL_LIMIT: reg_rdata = limit_q;
         default:    reg_rdata = '0;
      endcase
   end

   logic unused_wbits;
   assign unused_wbits = ^{reg_wdata[BIT_BUSY:9], reg_wdata[6], reg_wdata[3]};

   a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (hit_q && ctrl_q.hit_ie));
   a_r11_dma_routed: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> ($past(ctrl_q.route) == ROUTE_DMA));
   a_r4_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run_en) && !$past(busy)) |-> $stable(count));
   a_r6_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ctrl_q.cont) && $past(hit_q) && !$past(busy)) |-> $stable(count));
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hit_q) && !$past(wr_ctrl)) |-> hit_q);

endmodule

// File: tb/match_timer_tb_top.sv
module match_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, dma_req;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   match_timer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .reg_sel   (reg_sel),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq),
      .dma_req   (dma_req)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] v);
      reg_sel = s; reg_wdata = v; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [31:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   task automatic set_count(input logic [31:0] v);
      wr(2'd1, v);
      repeat (3) @(negedge clk);
   endtask

   task automatic run_for(input int e);
      run_en = 1'b1;
      repeat (e) @(negedge clk);
      run_en = 1'b0;
   endtask

   function automatic int ratio_log(input logic [2:0] sel);
      case (sel)
         3'd4: return 3;
         3'd5: return 5;
         3'd6: return 7;
         default: return 0;
      endcase
   endfunction

   function automatic logic [31:0] exp_count(input int ticks, input logic [31:0] lim);
      return 32'(ticks % (int'(lim) + 1));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, v); check("R1 ctrl reset", v, 32'h0);
      rd(2'd1, v); check("R1 count reset", v, 32'h0);
      rd(2'd2, v); check("R1 limit reset", v, 32'hFFFF_FFFF);
      check("R1 irq reset", {31'b0, irq}, 32'h0);
      check("R1 dma reset", {31'b0, dma_req}, 32'h0);

      // R12 compare write, R2 selector 3 ignored
      wr(2'd2, 32'h0000_1234);
      rd(2'd2, v); check("R12 limit readback", v, 32'h0000_1234);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd3, v); check("R2 sel3 reads zero", v, 32'h0);
      rd(2'd0, v); check("R2 sel3 write no ctrl effect", v, 32'h0);
      rd(2'd2, v); check("R2 sel3 write no limit effect", v, 32'h0000_1234);
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); check("R2 ctrl field layout", v, 32'h0000_01B7);

      // R3 non-ratio select: no counting
      wr(2'd0, 32'h0000_0100);
      wr(2'd2, 32'hFFFF_FFFF);
      run_for(20);
      rd(2'd1, v); check("R3 stopped select", v, 32'h0);

      // R9 staged counter write
      wr(2'd1, 32'h0000_0055);
      rd(2'd0, v); check("R9 busy edge1", {31'b0, v[13]}, 32'h1);
      rd(2'd1, v); check("R9 not yet loaded", v, 32'h0);
      @(negedge clk);
      rd(2'd0, v); check("R9 busy edge2", {31'b0, v[13]}, 32'h1);
      @(negedge clk);
      rd(2'd0, v); check("R9 busy edge3", {31'b0, v[13]}, 32'h1);
      @(negedge clk);
      rd(2'd0, v); check("R9 busy cleared", {31'b0, v[13]}, 32'h0);
      rd(2'd1, v); check("R9 value loaded", v, 32'h55);

      // R9 load wins over count; R4 freeze
      wr(2'd0, 32'h0000_0107);
      run_en = 1'b1;
      wr(2'd1, 32'h0000_0100);
      repeat (3) @(negedge clk);
      run_en = 1'b0;
      rd(2'd1, v); check("R9 load beats count", v, 32'h100);
      repeat (20) @(negedge clk);
      rd(2'd1, v); check("R4 frozen while stopped", v, 32'h100);

      // R6 single mode hold
      wr(2'd0, 32'h0000_0007);
      wr(2'd2, 32'h3);
      set_count(32'h0);
      run_for(10);
      rd(2'd1, v); check("R6 held at zero", v, 32'h0);
      rd(2'd0, v); check("R6 hit flag set", {31'b0, v[15]}, 32'h1);
      wr(2'd0, 32'h0000_0007);
      run_for(2);
      rd(2'd1, v); check("R6 resumes after clear", v, 32'h2);

      // R7 wrap without match
      wr(2'd0, 32'h0000_0107);
      wr(2'd2, 32'd10);
      set_count(32'hFFFF_FFFE);
      run_for(2);
      rd(2'd1, v); check("R7 wrapped to zero", v, 32'h0);
      rd(2'd0, v); check("R7 wrap flag", {30'b0, v[15:14]}, 32'h1);
      // R8 write one keeps, write zero clears
      wr(2'd0, 32'h0000_4107);
      rd(2'd0, v); check("R8 one keeps wrap", {31'b0, v[14]}, 32'h1);
      wr(2'd0, 32'h0000_0107);
      rd(2'd0, v); check("R8 zero clears wrap", {31'b0, v[14]}, 32'h0);

      // R7 full range with all-ones compare
      wr(2'd2, 32'hFFFF_FFFF);
      set_count(32'hFFFF_FFFE);
      run_for(2);
      rd(2'd1, v); check("R7 full-range wrap", v, 32'h0);
      rd(2'd0, v); check("R7 full-range hit not wrap", {30'b0, v[15:14]}, 32'h2);

      // R10 interrupt
      wr(2'd0, 32'h0000_01A7);
      wr(2'd2, 32'h3);
      set_count(32'h0);
      check("R10 irq low before match", {31'b0, irq}, 32'h0);
      run_for(4);
      check("R10 irq on match", {31'b0, irq}, 32'h1);
      wr(2'd0, 32'h0000_8127);
      check("R10 irq off without enable", {31'b0, irq}, 32'h0);
      rd(2'd0, v); check("R8 hit kept by one", {31'b0, v[15]}, 32'h1);
      wr(2'd0, 32'h0000_0127);
      rd(2'd0, v); check("R8 hit cleared by zero", {31'b0, v[15]}, 32'h0);

      // R11 DMA pulse
      wr(2'd0, 32'h0000_0197);
      set_count(32'h0);
      run_en = 1'b1;
      repeat (4) @(negedge clk);
      check("R11 dma pulse", {31'b0, dma_req}, 32'h1);
      check("R11 irq quiet on dma route", {31'b0, irq}, 32'h0);
      @(negedge clk);
      run_en = 1'b0;
      check("R11 dma one cycle", {31'b0, dma_req}, 32'h0);

      // R3 R5 random ratios and limits in continuous mode
      for (int i = 0; i < 24; i++) begin
         logic [2:0]  sel;
         logic [31:0] lim;
         int          e, ticks;
         sel   = 3'(4 + $urandom_range(0, 3));
         lim   = 32'($urandom_range(0, 20));
         e     = int'($urandom_range(1, 400));
         wr(2'd0, 32'h0000_0100 | 32'(sel));
         wr(2'd2, lim);
         set_count(32'h0);
         run_for(e);
         ticks = e >> ratio_log(sel);
         rd(2'd1, v); check("R3 R5 random count", v, exp_count(ticks, lim));
         rd(2'd0, v);
         check("R5 random hit flag", {31'b0, v[15]}, {31'b0, (ticks > int'(lim))});
         check("R7 random no wrap", {31'b0, v[14]}, 32'h0);
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule